// File: doc/BRIEF.md
# Speculative PAM4 Decision Feedback Equalizer

This block is the last stage of a parallel PAM4 receiver datapath. Each clock it accepts one block of equalized samples, one per lane, from the feed-forward equalizer in front of it. It removes the interference that the previous symbol leaves on the current one, using a single feedback weight. It then returns a 2-bit decision for every lane. Samples and the feedback weight are signed two's-complement values. The three slicer thresholds are supplied on ports, so the decision boundaries can follow the signal amplitude.

A direct parallel feedback equalizer has a serial path through every lane: a multiply, a subtract and a compare per lane, all inside one cycle. This block moves that arithmetic out of the loop. In the first stage, each lane forms its four possible corrected samples, one for each level the previous symbol could have had, and slices all four. In the second stage, a chain of 4:1 multiplexers runs in lane order and picks one of the four results. Lane 0 is steered by the final symbol of the previous block, and each later lane by the lane below it. The only path from one block to the next is a 2-bit history register, and it updates every cycle.

Top module: `pam4_spec_dfe`

## Requirements
- R1: Symbols use Gray coding: `2'b00` = −3, `2'b01` = −1, `2'b11` = +1, `2'b10` = +3. A corrected value c is decoded as `10` when c ≥ th_hi, as `11` when th_mid ≤ c < th_hi, as `01` when th_lo ≤ c < th_mid, and otherwise as `00`. A value equal to a threshold falls into the upper region.
- R2: The corrected value of lane k is x[k] − h1·L, where L is the level of the symbol decided for lane k−1 in the same block.
- R3: For lane 0, L is the level of the symbol that lane LANES−1 decided in the immediately preceding block.
- R4: While reset is high, every output symbol becomes `00` on the next clock edge. The history symbol also returns to `00`, so the first block after reset is corrected as though the previous symbol were −3.
- R5: A block presented at one rising edge appears on `sym_o` after the second rising edge that follows. A new block is accepted on every clock.
- R6: With h1 = 0, every lane's decision is the plain slice of its own sample, and the history has no influence on it.
- R7: Changing any threshold moves the decision boundaries to the new values from the next block onward. This holds for asymmetric settings as well.
- R8: The corrected value is computed without wrap-around over the full input ranges. For example, x = +127 and h1 = −32 with a previous symbol of +3 gives +223.
- R9: Lane k occupies `x_i[k*SW +: SW]` on the input and `sym_o[2k +: 2]` on the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| x_i | input | LANES*SW | Packed equalized samples, signed per lane, lane 0 in the low bits |
| h1_i | input | HW | Signed first post-cursor feedback weight |
| th_lo_i | input | SW | Signed lower slicer threshold |
| th_mid_i | input | SW | Signed middle slicer threshold |
| th_hi_i | input | SW | Signed upper slicer threshold |
| sym_o | output | 2*LANES | Registered Gray-coded symbols, lane 0 in the low bits |

## Verification
A wrong history symbol shows first as a wrong lane 0 decision, two cycles after the block it affects has entered. From there the error spreads up the lanes wherever the previous level matters. The bench therefore uses a serial lane-by-lane model that carries the history across blocks, and it compares every block in full. A wrong speculative candidate shows only when its lane's predecessor takes the matching level. Long random runs with positive, negative and zero weights give every predecessor level a chance to steer each lane. A slicing error at a boundary shows in the same block. Samples placed exactly on and beside each threshold expose it, under both symmetric and asymmetric threshold settings.

// File: rtl/pam4_dfe_pkg.sv
`timescale 1ns/1ps
package pam4_dfe_pkg;

  // Internal arithmetic width; wide enough for SW + HW + 3 at any sensible setting.
  localparam int AW = 24;

  typedef logic signed [AW-1:0] arith_t;
  typedef logic [1:0]           sym_t;

  localparam sym_t SYM_M3 = 2'b00;
  localparam sym_t SYM_M1 = 2'b01;
  localparam sym_t SYM_P1 = 2'b11;
  localparam sym_t SYM_P3 = 2'b10;

  // Gray symbol -> ordinal index 0..3 (ascending level).
  function automatic logic [1:0] sym_to_idx(input sym_t s);
    case (s)
      SYM_M3:  return 2'd0;
      SYM_M1:  return 2'd1;
      SYM_P1:  return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  // Ordinal index -> signed level -3, -1, +1, +3.
  function automatic arith_t idx_to_level(input logic [1:0] i);
    case (i)
      2'd0:    return -arith_t'(3);
      2'd1:    return -arith_t'(1);
      2'd2:    return  arith_t'(1);
      default: return  arith_t'(3);
    endcase
  endfunction

  // Corrected sample assuming the previous symbol had ordinal index i.
  function automatic arith_t spec_candidate(input arith_t x, input arith_t h1,
                                            input logic [1:0] i);
    return x - h1 * idx_to_level(i);
  endfunction

  // Three-threshold slicer; ties resolve to the upper region.
  function automatic sym_t slice3(input arith_t c, input arith_t lo,
                                  input arith_t mid, input arith_t hi);
    if (c >= hi)       return SYM_P3;
    else if (c >= mid) return SYM_P1;
    else if (c >= lo)  return SYM_M1;
    else               return SYM_M3;
  endfunction

endpackage

// File: rtl/pam4_spec_slicer.sv
`timescale 1ns/1ps
// One lane of the speculative stage: four corrected candidates, each sliced.
// Output slot g holds the decision assuming the prior symbol had ordinal index g.
module pam4_spec_slicer
  import pam4_dfe_pkg::*;
#(
  parameter int SW = 8,
  parameter int HW = 6
) (
  input  logic signed [SW-1:0] x_i,
  input  logic signed [HW-1:0] h1_i,
  input  logic signed [SW-1:0] th_lo_i,
  input  logic signed [SW-1:0] th_mid_i,
  input  logic signed [SW-1:0] th_hi_i,
  output sym_t        [3:0]    spec_o
);

  localparam int NCAND = 4;

  arith_t x_w, h_w, lo_w, mid_w, hi_w;

  assign x_w   = arith_t'(x_i);
  assign h_w   = arith_t'(h1_i);
  assign lo_w  = arith_t'(th_lo_i);
  assign mid_w = arith_t'(th_mid_i);
  assign hi_w  = arith_t'(th_hi_i);

  for (genvar g = 0; g < NCAND; g++) begin : g_cand
    arith_t cand;
    assign cand      = spec_candidate(x_w, h_w, 2'(g));
    assign spec_o[g] = slice3(cand, lo_w, mid_w, hi_w);
  end

endmodule

// File: rtl/pam4_resolve_chain.sv
`timescale 1ns/1ps
// Lane-ordered selection: each lane's prior symbol steers a 4:1 mux over its
// pre-sliced candidates. No arithmetic sits on this path.
module pam4_resolve_chain
  import pam4_dfe_pkg::*;
#(
  parameter int LANES = 32
) (
  input  sym_t [LANES-1:0][3:0] spec_i,
  input  sym_t                  hist_i,
  output sym_t [LANES-1:0]      pick_o
);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    sym_t prior;
    sym_t pick;
    if (k == 0) begin : g_head
      assign prior = hist_i;
    end else begin : g_link
      assign prior = g_lane[k-1].pick;
    end
    assign pick      = spec_i[k][sym_to_idx(prior)];
    assign pick_o[k] = pick;
  end

endmodule

// File: rtl/pam4_spec_dfe.sv
`timescale 1ns/1ps
// Speculative PAM4 decision feedback equalizer, first post-cursor tap.
// Stage 1: per-lane speculative slicing, registered.
// Stage 2: lane-ordered resolution against the carried history, registered.
module pam4_spec_dfe
  import pam4_dfe_pkg::*;
#(
  parameter int LANES = 32,
  parameter int SW    = 8,
  parameter int HW    = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [LANES*SW-1:0]    x_i,
  input  logic signed [HW-1:0]   h1_i,
  input  logic signed [SW-1:0]   th_lo_i,
  input  logic signed [SW-1:0]   th_mid_i,
  input  logic signed [SW-1:0]   th_hi_i,
  output logic [2*LANES-1:0]     sym_o
);

  localparam int LAST = LANES - 1;

  sym_t [LANES-1:0][3:0] spec_d, spec_q;
  sym_t [LANES-1:0]      pick, sym_q;
  sym_t                  hist;

  // ---------------- stage 1: speculate ----------------
  for (genvar k = 0; k < LANES; k++) begin : g_slc
    pam4_spec_slicer #(.SW(SW), .HW(HW)) u_slc (
      .x_i      (x_i[k*SW +: SW]),
      .h1_i     (h1_i),
      .th_lo_i  (th_lo_i),
      .th_mid_i (th_mid_i),
      .th_hi_i  (th_hi_i),
      .spec_o   (spec_d[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) spec_q <= '0;
    else     spec_q <= spec_d;
  end

  // ---------------- stage 2: resolve ----------------
  // History is the top lane of the last resolved block; updated every cycle.
  assign hist = sym_q[LAST];

  pam4_resolve_chain #(.LANES(LANES)) u_chain (
    .spec_i (spec_q),
    .hist_i (hist),
    .pick_o (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) sym_q <= '0;
    else     sym_q <= pick;
  end

  assign sym_o = sym_q;

  // ---------------- observation wires for the assertions ----------------
  logic [1:0]           warm;       // cycles since reset, saturating at 3
  logic                 thr_order;  // thresholds ascending on the inputs
  logic [LANES-1:0]     lane_agree; // all four candidates identical
  logic [LANES-1:0]     lane_mono;  // candidate levels non-increasing in slot
  logic [2*LANES-1:0]   spec0_vec;  // slot-0 candidates packed per lane

  always_ff @(posedge clk) begin
    if (rst)              warm <= 2'd0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  assign thr_order = (th_lo_i <= th_mid_i) && (th_mid_i <= th_hi_i);

  for (genvar k = 0; k < LANES; k++) begin : g_obs
    assign lane_agree[k] = (spec_q[k][0] == spec_q[k][1]) &&
                           (spec_q[k][1] == spec_q[k][2]) &&
                           (spec_q[k][2] == spec_q[k][3]);
    assign lane_mono[k]  = (sym_to_idx(spec_q[k][0]) >= sym_to_idx(spec_q[k][1])) &&
                           (sym_to_idx(spec_q[k][1]) >= sym_to_idx(spec_q[k][2])) &&
                           (sym_to_idx(spec_q[k][2]) >= sym_to_idx(spec_q[k][3]));
    assign spec0_vec[2*k +: 2] = spec_q[k][0];
  end

  // R4: reset clears every output symbol on the following edge.
  a_r4_reset_clears: assert property (@(posedge clk)
    rst |=> (sym_o == '0));

  // R2: a non-negative weight makes a lower assumed prior level give an
  // equal or higher decision, given ordered thresholds.
  a_r2_spec_monotone: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && $past(h1_i) >= 0 && $past(thr_order)) |-> (&lane_mono));

  // R6: a zero weight leaves nothing to speculate on.
  a_r6_flat_tap_agree: assert property (@(posedge clk) disable iff (rst)
    (warm != 2'd0 && $past(h1_i) == 0) |-> (&lane_agree));

  // R6: with a zero weight the resolved block ignores history entirely.
  a_r6_history_ignored: assert property (@(posedge clk) disable iff (rst)
    (warm >= 2'd2 && $past(h1_i, 2) == 0) |-> (sym_o == $past(spec0_vec)));

endmodule

// File: tb/tb_pam4_spec_dfe.sv
`timescale 1ns/1ps
module tb_pam4_spec_dfe;

  localparam int LANES = 32;
  localparam int SW    = 8;
  localparam int HW    = 6;
  localparam int OW    = 2 * LANES;

  logic                  clk = 1'b0;
  logic                  rst = 1'b1;
  logic [LANES*SW-1:0]   x_i = '0;
  logic signed [HW-1:0]  h1_i = '0;
  logic signed [SW-1:0]  th_lo_i = -8'sd32;
  logic signed [SW-1:0]  th_mid_i = 8'sd0;
  logic signed [SW-1:0]  th_hi_i = 8'sd32;
  logic [OW-1:0]         sym_o;

  always #4 clk = ~clk;   // 125 MHz

  pam4_spec_dfe #(.LANES(LANES), .SW(SW), .HW(HW)) dut (
    .clk(clk), .rst(rst), .x_i(x_i), .h1_i(h1_i),
    .th_lo_i(th_lo_i), .th_mid_i(th_mid_i), .th_hi_i(th_hi_i),
    .sym_o(sym_o)
  );

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  int         xv [LANES];
  logic [1:0] model_hist = 2'b00;

  logic [OW-1:0] exp_q [$];
  int            due_q [$];
  string         tag_q [$];

  // Gray symbol -> level, restated from R1.
  function automatic int lvl(input logic [1:0] s);
    case (s)
      2'b00:   return -3;
      2'b01:   return -1;
      2'b11:   return 1;
      default: return 3;
    endcase
  endfunction

  function automatic logic [1:0] slc(input int c, input int lo, input int mid, input int hi);
    if (c >= hi)  return 2'b10;
    if (c >= mid) return 2'b11;
    if (c >= lo)  return 2'b01;
    return 2'b00;
  endfunction

  // Driver: one block per call, consecutive calls are consecutive cycles.
  // Serial lane-by-lane reference model (R2, R3) pushes the expected block.
  task automatic apply(input int h1, input int lo, input int mid, input int hi,
                       input string tag, input bit release_rst);
    logic [OW-1:0] e;
    logic [1:0]    prev;
    @(negedge clk);
    if (release_rst) rst = 1'b0;
    h1_i     = HW'(h1);
    th_lo_i  = SW'(lo);
    th_mid_i = SW'(mid);
    th_hi_i  = SW'(hi);
    prev = model_hist;
    for (int k = 0; k < LANES; k++) begin
      int c;
      x_i[k*SW +: SW] = SW'(xv[k]);
      c = xv[k] - h1 * lvl(prev);
      prev = slc(c, lo, mid, hi);
      e[2*k +: 2] = prev;
    end
    model_hist = prev;
    exp_q.push_back(e);
    due_q.push_back(cyc + 2);   // R5: two rising edges of latency
    tag_q.push_back(tag);
  endtask

  // Monitor / scoreboard.
  always @(posedge clk) begin
    #1;
    cyc = cyc + 1;
    if (due_q.size() > 0 && due_q[0] == cyc) begin
      logic [OW-1:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      void'(due_q.pop_front());
      n_vec = n_vec + 1;
      if (sym_o !== e) begin
        n_bad = n_bad + 1;
        $display("FAIL %s: sym_o=%h expected %h", t, sym_o, e);
      end
    end
  end

  task automatic check_zero(input string tag);
    n_vec = n_vec + 1;
    if (sym_o !== '0) begin
      n_bad = n_bad + 1;
      $display("FAIL %s: sym_o=%h expected %h", tag, sym_o, {OW{1'b0}});
    end
  endtask

  task automatic drain();
    while (due_q.size() > 0) @(posedge clk);
    @(posedge clk);
    #2;
  endtask

  task automatic rand_block(input int lo_v, input int hi_v);
    for (int k = 0; k < LANES; k++)
      xv[k] = lo_v + int'($urandom_range(hi_v - lo_v));
  endtask

  initial begin : main
    int pts [8];
    pts = '{-128, -33, -32, -1, 0, 31, 32, 127};

    // R4: reset state
    repeat (3) @(posedge clk);
    #1 check_zero("R4 reset state");

    // R1 / R6 / R9: h1 = 0, samples on and beside each threshold, per lane
    for (int k = 0; k < LANES; k++) xv[k] = pts[k % 8];
    apply(0, -32, 0, 32, "R1 R6 R9 threshold ties, h1=0", 1'b1);
    for (int k = 0; k < LANES; k++) xv[k] = pts[(k + 3) % 8];
    apply(0, -32, 0, 32, "R1 R6 rotated boundary set", 1'b0);
    rand_block(-128, 127);
    apply(0, -32, 0, 32, "R6 random with zero weight", 1'b0);

    // R3: last lane +3 then lane 0 decision depends on it
    for (int k = 0; k < LANES; k++) xv[k] = 127;
    apply(20, -32, 0, 32, "R3 prime history +3", 1'b0);
    for (int k = 0; k < LANES; k++) xv[k] = 40;
    apply(20, -32, 0, 32, "R3 lane0 follows previous block", 1'b0);
    for (int k = 0; k < LANES; k++) xv[k] = -127;
    apply(20, -32, 0, 32, "R3 prime history -3", 1'b0);
    for (int k = 0; k < LANES; k++) xv[k] = -40;
    apply(20, -32, 0, 32, "R3 lane0 follows previous block", 1'b0);

    // R2 / R5: random streams, positive and negative weights, back to back
    for (int b = 0; b < 40; b++) begin
      rand_block(-110, 110);
      apply(12, -32, 0, 32, "R2 R5 random stream h1=12", 1'b0);
    end
    for (int b = 0; b < 30; b++) begin
      rand_block(-110, 110);
      apply(-9, -32, 0, 32, "R2 random stream h1=-9", 1'b0);
    end

    // R7: asymmetric thresholds, then a change mid-stream
    for (int b = 0; b < 20; b++) begin
      rand_block(-90, 90);
      apply(7, -10, 5, 50, "R7 asymmetric thresholds", 1'b0);
    end
    for (int b = 0; b < 10; b++) begin
      rand_block(-90, 90);
      apply(7, -60, -20, 10, "R7 thresholds moved", 1'b0);
    end

    // R8: extreme samples and weights, no wrap-around
    for (int k = 0; k < LANES; k++) xv[k] = (k % 2 == 0) ? 127 : -128;
    apply(-32, -100, 0, 100, "R8 extremes h1=-32", 1'b0);
    apply(31, -100, 0, 100, "R8 extremes h1=31", 1'b0);
    for (int b = 0; b < 10; b++) begin
      rand_block(-128, 127);
      apply(-32, -127, 0, 127, "R8 random extremes", 1'b0);
    end

    // R4: reset mid-run; first block afterwards assumes prior -3
    drain();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 check_zero("R4 reset mid-run");
    model_hist = 2'b00;
    for (int k = 0; k < LANES; k++) xv[k] = 40;
    apply(20, -32, 0, 32, "R4 history cleared by reset", 1'b1);
    for (int b = 0; b < 8; b++) begin
      rand_block(-100, 100);
      apply(15, -32, 0, 32, "R2 stream after reset", 1'b0);
    end

    drain();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog: run hung, actual cycles=%0d expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule